// File: doc/BRIEF.md
# Subcode Q-Channel Capture and Serial Readout

This block collects the Q channel of the disc subcode, one bit per symbol, into an 80-stage shift register. A write strobe marks each subcode symbol. A rising edge on the block sync input closes a block. At that point the block checks the captured bits against a 16-bit CRC, freezes the register and hands it to a host. The host has its own clock and reads the bits serially. Each falling edge of that clock advances the data line by one bit, and the bits come out in the order they arrived.

The pass/fail result of the check drives a status output, which is high when the check passed. A configuration input is latched at the sync edge. When it is set, the first thing on the data line is the pass/fail flag, and the first captured bit follows the first falling host-clock edge. After the last bit has been shifted out, the block goes back to capturing. A sync edge during readout also sends it back to capturing, and the next sync edge then closes the new block.

Top module: `subq_capture`

## Requirements
- R1: After synchronous reset the block is capturing, `q_dout` is 0 and `crc_ok` is 0.
- R2: While capturing, each cycle with `wr_stb` high shifts `q_bit` into the register. The first bit of a block is bit 1, bits 1 to 64 are the payload and bits 65 to 80 are the check field.
- R3: Once 80 bits have been captured, further strobes in the same block are ignored. Those 80 bits are the ones read out later.
- R4: A rising edge of `blk_sync` while capturing ends the block. `crc_ok` becomes 1 only if exactly 80 bits were captured and bits 65 to 80 equal the bitwise inverse of the CRC of bits 1 to 64. The CRC uses polynomial x^16+x^12+x^5+1, an initial value of 0, and takes the payload and the check field most significant first. `crc_ok` changes at no other time.
- R5: If `crc_flag_en` was 1 at the sync edge, `q_dout` shows `crc_ok` until the first falling edge of `host_clk`. Bit 1 follows that edge.
- R6: If `crc_flag_en` was 0 at the sync edge, `q_dout` shows bit 1 straight after the sync edge.
- R7: During readout, each falling edge of `host_clk` moves `q_dout` to the next bit, from bit 1 through bit 80.
- R8: During readout the register is frozen. Strobes and Q bits have no effect on the bits read out.
- R9: The falling host-clock edge that moves past bit 80 ends the readout. The block then captures again, and `q_dout` reads 0.
- R10: A `blk_sync` rising edge during readout abandons it and starts a fresh capture from bit 1. `crc_ok` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe per subcode symbol |
| q_bit | input | 1 | Q channel bit of the current symbol |
| blk_sync | input | 1 | Block sync level; its rising edge is the event |
| crc_flag_en | input | 1 | Show the check result on the data line before bit 1 |
| host_clk | input | 1 | Host readout clock, asynchronous, idles high |
| q_dout | output | 1 | Serial Q data / check flag to host |
| crc_ok | output | 1 | High when the last closed block passed its check |

## Verification
The assertions assume that `blk_sync` and `wr_stb` are synchronous to `clk`. They also assume that a sync rising edge never falls in the same cycle as a strobe. The host-clock input must stay low and high for longer than the synchronizer latency, so that every falling edge gives exactly one internal event. The bench drives all inputs on the falling edge of `clk`. It keeps strobes one idle cycle apart and holds sync high for two cycles, away from any strobe. It holds each host-clock phase for four block cycles.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
package sq_pkg;
  typedef enum logic {
    MODE_CAP  = 1'b0,
    MODE_HOLD = 1'b1
  } sq_mode_e;
endpackage

// File: rtl/sq_fall_det.sv
`timescale 1ns/1ps
// Brings an asynchronous host clock into the block clock domain and
// emits a one-cycle pulse on each falling edge.
module sq_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      fall  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-1:0], async_in};
      fall  <= chain[STAGES] & ~chain[STAGES-1];
    end
  end

  // One falling edge never yields two adjacent events (R7)
  assert_fall_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/sq_crc_track.sv
`timescale 1ns/1ps
// Serial CRC over the payload bits, then a bit-by-bit comparison of the
// check field against the inverted remainder.
module sq_crc_track #(
  parameter int                 CRC_W     = 16,
  parameter logic [CRC_W-1:0]   POLY      = 'h1021,
  parameter int                 DATA_BITS = 64,
  parameter int                 CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic [CNT_W-1:0] pos,
  output logic             match
);
  localparam logic [CNT_W-1:0] DATA_LIM = CNT_W'(DATA_BITS);

  logic [CRC_W-1:0] crc;
  logic             bad;
  logic             fb;

  assign fb = crc[CRC_W-1] ^ bit_val;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc <= '0;
      bad <= 1'b0;
    end else if (bit_vld) begin
      if (pos < DATA_LIM) begin
        crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end else begin
        if (bit_val == crc[CRC_W-1]) bad <= 1'b1;
        crc <= {crc[CRC_W-2:0], 1'b0};
      end
    end
  end

  assign match = !bad;

  // A cleared tracker starts a block with no mismatch recorded (R4)
  assert_clr_clean_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> match);
endmodule

// File: rtl/subq_capture.sv
`timescale 1ns/1ps
module subq_capture #(
  parameter int               DATA_BITS   = 64,
  parameter int               CRC_W       = 16,
  parameter logic [CRC_W-1:0] CRC_POLY    = 'h1021,
  parameter int               SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic q_bit,
  input  logic blk_sync,
  input  logic crc_flag_en,
  input  logic host_clk,
  output logic q_dout,
  output logic crc_ok
);
  import sq_pkg::*;

  localparam int               TOTAL = DATA_BITS + CRC_W;
  localparam int               CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] TOT_C = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  sq_mode_e         mode;
  logic [TOTAL-1:0] shreg;
  logic [CNT_W-1:0] cap_cnt;
  logic [CNT_W-1:0] rd_left;
  logic             flag_phase;
  logic             crc_ok_q;
  logic             sync_q;

  logic sync_rise, host_fall, crc_match;
  logic take_bit, freeze, shift_out, leave_hold, flag_drop;

  sq_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
    .clk      (clk),
    .rst      (rst),
    .async_in (host_clk),
    .fall     (host_fall)
  );

  assign sync_rise  = blk_sync & ~sync_q;
  assign freeze     = (mode == MODE_CAP) && sync_rise;
  assign take_bit   = (mode == MODE_CAP) && wr_stb && !sync_rise && (cap_cnt < TOT_C);
  assign shift_out  = (mode == MODE_HOLD) && !sync_rise && host_fall && !flag_phase;
  assign flag_drop  = (mode == MODE_HOLD) && !sync_rise && host_fall && flag_phase;
  assign leave_hold = (mode == MODE_HOLD) && (sync_rise || (shift_out && rd_left == ONE_C));

  sq_crc_track #(
    .CRC_W     (CRC_W),
    .POLY      (CRC_POLY),
    .DATA_BITS (DATA_BITS),
    .CNT_W     (CNT_W)
  ) u_crc (
    .clk     (clk),
    .rst     (rst),
    .clr     (leave_hold),
    .bit_vld (take_bit),
    .bit_val (q_bit),
    .pos     (cap_cnt),
    .match   (crc_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= MODE_CAP;
      shreg      <= '0;
      cap_cnt    <= '0;
      rd_left    <= '0;
      flag_phase <= 1'b0;
      crc_ok_q   <= 1'b0;
      sync_q     <= 1'b0;
    end else begin
      sync_q <= blk_sync;
      if (freeze) begin
        mode       <= MODE_HOLD;
        crc_ok_q   <= (cap_cnt == TOT_C) && crc_match;
        flag_phase <= crc_flag_en;
        rd_left    <= TOT_C;
      end else if (leave_hold) begin
        mode       <= MODE_CAP;
        shreg      <= '0;
        cap_cnt    <= '0;
        rd_left    <= '0;
        flag_phase <= 1'b0;
      end else if (take_bit) begin
        shreg   <= {shreg[TOTAL-2:0], q_bit};
        cap_cnt <= cap_cnt + ONE_C;
      end else if (shift_out) begin
        shreg   <= {shreg[TOTAL-2:0], 1'b0};
        rd_left <= rd_left - ONE_C;
      end else if (flag_drop) begin
        flag_phase <= 1'b0;
      end
    end
  end

  assign crc_ok = crc_ok_q;
  assign q_dout = (mode == MODE_HOLD) ? (flag_phase ? crc_ok_q : shreg[TOTAL-1]) : 1'b0;

  // Capture count never runs past the register length (R3)
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cap_cnt <= TOT_C);

  // Without a host edge or sync, the held register does not move (R8)
  assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD && !sync_rise && !host_fall) |=> $stable(shreg));

  // The check result only changes when a capture closes (R4)
  assert_crc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(mode == MODE_CAP && sync_rise) |=> $stable(crc_ok));

  // A block of the wrong length never passes (R4)
  assert_short_fail_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CAP && sync_rise && cap_cnt != TOT_C) |=> !crc_ok);

  // Readout always has bits left while holding (R9)
  assert_rd_live_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD) |-> (rd_left != '0));

  // Once gone, the flag phase does not return within a readout (R5)
  assert_flag_once_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD && !flag_phase && !sync_rise) |=> !flag_phase);
endmodule

// File: tb/subq_capture_bench.sv
`timescale 1ns/1ps
module subq_capture_bench;
  typedef struct packed {
    logic [63:0] data;
    logic [15:0] chk_xor;
    logic        flag;
    logic        exp_ok;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{64'h0123_4567_89AB_CDEF, 16'h0000, 1'b1, 1'b1},
    '{64'h0000_0000_0000_0000, 16'h0000, 1'b0, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 16'h0001, 1'b1, 1'b0},
    '{64'h4100_0101_0000_2345, 16'h8000, 1'b0, 1'b0},
    '{64'hDEAD_BEEF_CAFE_F00D, 16'h0000, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0, q_bit = 1'b0, blk_sync = 1'b0;
  logic crc_flag_en = 1'b0, host_clk = 1'b1;
  logic q_dout, crc_ok;
  int   n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  subq_capture u_subq_capture (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .q_bit(q_bit),
    .blk_sync(blk_sync), .crc_flag_en(crc_flag_en), .host_clk(host_clk),
    .q_dout(q_dout), .crc_ok(crc_ok)
  );

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [63:0] d);
    logic [15:0] c = '0;
    for (int i = 63; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [79:0] mk_block(input logic [63:0] d, input logic [15:0] x);
    return {d, ~ref_crc(d) ^ x};
  endfunction

  task automatic strobe(input logic b);
    @(negedge clk); q_bit = b; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0; q_bit = ~b;
  endtask

  task automatic feed(input logic [79:0] blk, input int n);
    for (int i = 0; i < n; i++) strobe(blk[79-i]);
  endtask

  task automatic sync_pulse(input logic flag);
    @(negedge clk); crc_flag_en = flag; blk_sync = 1'b1;
    repeat (2) @(negedge clk);
    blk_sync = 1'b0; crc_flag_en = ~flag;
    @(negedge clk);
  endtask

  task automatic hpulse();
    @(negedge clk); host_clk = 1'b0;
    repeat (4) @(negedge clk);
    host_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_n(input int n, output logic [79:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got[79-i] = q_dout;
      hpulse();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [79:0] blk, blk2, got;
    repeat (4) @(negedge clk);
    check("R1 reset q_dout", {79'b0, q_dout}, 80'd0);
    check("R1 reset crc_ok", {79'b0, crc_ok}, 80'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      blk = mk_block(VECS[v].data, VECS[v].chk_xor);
      feed(blk, 80);
      sync_pulse(VECS[v].flag);
      check($sformatf("R4 crc_ok vec%0d", v), {79'b0, crc_ok}, {79'b0, VECS[v].exp_ok});
      if (VECS[v].flag) begin
        check($sformatf("R5 flag vec%0d", v), {79'b0, q_dout}, {79'b0, VECS[v].exp_ok});
        hpulse();
      end else begin
        check($sformatf("R6 first bit vec%0d", v), {79'b0, q_dout}, {79'b0, blk[79]});
      end
      read_n(80, got);
      check($sformatf("R2 R7 readout vec%0d", v), got, blk);
      check($sformatf("R9 idle after readout vec%0d", v), {79'b0, q_dout}, 80'd0);
    end

    // R3: extra strobes after a full block are dropped
    blk = mk_block(64'h5A5A_0F0F_3C3C_9669, 16'h0);
    feed(blk, 80);
    feed(~blk, 5);
    sync_pulse(1'b0);
    check("R3 crc_ok with extra strobes", {79'b0, crc_ok}, 80'd1);
    read_n(80, got);
    check("R3 readout ignores extras", got, blk);

    // R8: strobes during readout leave the held bits alone
    blk2 = mk_block(64'h1357_9BDF_2468_ACE0, 16'h0);
    feed(blk2, 80);
    sync_pulse(1'b0);
    read_n(3, got);
    feed(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 10);
    check("R8 bit4 after strobes in hold", {79'b0, q_dout}, {79'b0, blk2[76]});
    read_n(77, got);
    check("R8 remaining bits", got[79:3], blk2[76:0]);

    // R4: short block fails
    feed(blk2, 79);
    sync_pulse(1'b1);
    check("R4 short block fails", {79'b0, crc_ok}, 80'd0);
    check("R5 flag shows fail", {79'b0, q_dout}, 80'd0);

    // R10: sync during readout restarts capture, crc_ok retained
    sync_pulse(1'b0);
    check("R10 crc_ok retained", {79'b0, crc_ok}, 80'd0);
    check("R10 back to capture", {79'b0, q_dout}, 80'd0);
    feed(blk, 80);
    sync_pulse(1'b0);
    check("R10 fresh block passes", {79'b0, crc_ok}, 80'd1);
    read_n(5, got);
    sync_pulse(1'b0);
    check("R10 crc_ok kept after abandon", {79'b0, crc_ok}, 80'd1);
    blk2 = mk_block(64'h8000_0000_0000_0001, 16'h0100);
    feed(blk2, 80);
    sync_pulse(1'b0);
    check("R10 new bad block", {79'b0, crc_ok}, 80'd0);
    read_n(80, got);
    check("R10 new block readout", got, blk2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule